// File: doc/BRIEF.md
# Multichannel Doorbell Mailbox

This block carries short messages between a host processor and an embedded controller over twelve independent channels. Both sides share one data store of 92 32-bit words. Each channel owns a fixed outgoing slot and a fixed incoming slot in that store, and the slots differ in length. The host writes an outgoing message word by word, in ascending order, into its channel's slot and then rings that channel's doorbell. A per-channel pending bit stays set until the controller acknowledges the message. The host polls that bit to learn when it may send again.

In the other direction the controller writes its reply into the channel's incoming slot through its own word port and then posts the channel. The post sets a receive status bit. Any set receive bit raises the single shared host interrupt. The host reads the slot and clears the bit by writing a one to it in the clear register. The host selects one of two windows with `hostCtl`: the data window or the control window. Only whole-word accesses exist, and host reads are combinational.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset all transmit and receive status bits are 0, `txPending` is 0 and `hostIrq` is low.
- R2: The data window holds 92 words at byte offsets 0x000 to 0x16C. A host write to word k (byte address 4k) is visible on the next cycle to host reads and to remote reads of index k. A remote write becomes visible to the host in the same way.
- R3: A host write to control offset 0x04 sets transmit status bit n, for channel n, for every bit n of the write data that is 1. `txPending` mirrors the transmit status.
- R4: Control offset 0x00 reads the transmit status in bits 11:0. Bit n stays 1 until `txAck[n]` clears it. If a doorbell and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: `rxPost[n]` sets receive status bit n, which reads at control offset 0x78 in bits 11:0.
- R6: A host write to control offset 0x74 clears receive bit n for every 1 in bit n of the data. Bits written as 0 leave their status unchanged. If a clear and a post hit the same bit in the same cycle, the post wins.
- R7: `hostIrq` is high exactly when at least one receive status bit is 1.
- R8: Control reads return 0 in bits 31:12. Offsets 0x04, 0x74 and all unused control offsets read 0. Host writes to offsets 0x00 and 0x78 change nothing.
- R9: Data-window byte addresses 0x170 and above read 0 and ignore writes, for both the host and the remote (remote index 92 and above).
- R10: If the host and the remote write the same data word in the same cycle, the remote value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe, one word per cycle |
| hostCtl | input | 1 | 1 selects the control window, 0 selects the data window |
| hostAddr | input | 9 | Host byte address; bits 1:0 are ignored |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for `hostAddr` (combinational) |
| hostIrq | output | 1 | Shared receive interrupt, level high |
| remWe | input | 1 | Remote data write strobe |
| remAddr | input | 7 | Remote word index |
| remWdata | input | 32 | Remote write data |
| remRdata | output | 32 | Remote read data at `remAddr` (combinational) |
| txAck | input | 12 | Per-channel acknowledge strobes; clear transmit status |
| rxPost | input | 12 | Per-channel post strobes; set receive status |
| txPending | output | 12 | Per-channel pending doorbells toward the remote |

## Verification
Three pairs of functions can land on the same cycle. A doorbell can meet an acknowledge on one transmit bit. A host clear can meet a remote post on one receive bit. A host data write can meet a remote data write on one word. The bench provokes each pair by driving both strobes in a single cycle. It then judges the outcome against a behavioural model that applies the stated priority. The model is compared with `txPending` and `hostIrq` on every clock and with the host read-back of the status registers and data words.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_CH     = 12;
  localparam int DATA_WORDS = 92;
  localparam int ADDR_W     = 9;
  localparam int IDX_W      = ADDR_W - 2;

  // control window word offsets (byte offset >> 2)
  localparam logic [IDX_W-1:0] OFS_TXSTAT = 7'h00;
  localparam logic [IDX_W-1:0] OFS_RING   = 7'h01;
  localparam logic [IDX_W-1:0] OFS_RXCLR  = 7'h1D;
  localparam logic [IDX_W-1:0] OFS_RXSTAT = 7'h1E;

  typedef struct packed {
    logic             dataWe;
    logic [IDX_W-1:0] dataIdx;
    logic [31:0]      dataWdata;
  } mbxStrb_t;
endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int WORDS = DATA_WORDS,
  parameter int IW    = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  mbxStrb_t      strb,
  input  logic          remWe,
  input  logic [IW-1:0] remAddr,
  input  logic [31:0]   remWdata,
  output logic [31:0]   remRdata,
  output logic [31:0]   hostDataRd
);
  logic [31:0] store [WORDS];
  logic hostInRange, remInRange;

  assign hostInRange = 32'(strb.dataIdx) < WORDS;
  assign remInRange  = 32'(remAddr) < WORDS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else begin
      if (strb.dataWe && hostInRange) store[strb.dataIdx] <= strb.dataWdata;
      // R10: the remote write is issued last, so it takes the word
      if (remWe && remInRange) store[remAddr] <= remWdata;
    end
  end

  assign hostDataRd = hostInRange ? store[strb.dataIdx] : '0;
  assign remRdata   = remInRange  ? store[remAddr]      : '0;

  // R10
  remote_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remWe && strb.dataWe && remInRange && remAddr == strb.dataIdx)
    |=> (store[$past(remAddr)] == $past(remWdata)));
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  localparam int IW = AW - 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWe,
  input  logic           hostCtl,
  input  logic [AW-1:0]  hostAddr,
  input  logic [31:0]    hostWdata,
  input  logic [31:0]    hostDataRd,
  output logic [31:0]    hostRdata,
  output mbxStrb_t       strb,
  input  logic [NCH-1:0] txAck,
  input  logic [NCH-1:0] rxPost,
  output logic [NCH-1:0] txPending,
  output logic           hostIrq
);
  logic [NCH-1:0] txStat, rxStat, ringVec, clrVec;
  logic [IW-1:0]  wIdx;
  logic           ctlWe;
  logic [31:0]    ctlRd;
  logic           unusedLow;

  assign wIdx      = hostAddr[AW-1:2];
  assign unusedLow = ^{hostAddr[1:0], hostWdata[31:NCH]};
  assign ctlWe     = hostWe && hostCtl;
  assign ringVec   = (ctlWe && wIdx == OFS_RING)  ? hostWdata[NCH-1:0] : '0;
  assign clrVec    = (ctlWe && wIdx == OFS_RXCLR) ? hostWdata[NCH-1:0] : '0;

  assign strb.dataWe    = hostWe && !hostCtl;
  assign strb.dataIdx   = wIdx;
  assign strb.dataWdata = hostWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStat <= '0;
      rxStat <= '0;
    end else begin
      txStat <= (txStat & ~txAck) | ringVec;
      rxStat <= (rxStat & ~clrVec) | rxPost;
    end
  end

  always_comb begin
    ctlRd = '0;
    if (wIdx == OFS_TXSTAT)      ctlRd[NCH-1:0] = txStat;
    else if (wIdx == OFS_RXSTAT) ctlRd[NCH-1:0] = rxStat;
  end

  assign hostRdata = hostCtl ? ctlRd : hostDataRd;
  assign txPending = txStat;
  assign hostIrq   = |rxStat;

  // R3
  ring_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && wIdx == OFS_RING) |=>
      ((txPending & $past(hostWdata[NCH-1:0])) == $past(hostWdata[NCH-1:0])));
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txAck != '0 && !ctlWe) |=> ((txPending & $past(txAck)) == '0));
  // R6
  post_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPost != '0) |=> ((rxStat & $past(rxPost)) == $past(rxPost)));
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostIrq && rxPost == '0) |=> !hostIrq);
  // R8
  status_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && (wIdx == OFS_TXSTAT || wIdx == OFS_RXSTAT) && txAck == '0 && rxPost == '0)
    |=> ($stable(txPending) && $stable(rxStat)));
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
  import mbx_pkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int WORDS = DATA_WORDS,
  parameter int AW    = ADDR_W,
  localparam int IW   = AW - 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWe,
  input  logic           hostCtl,
  input  logic [AW-1:0]  hostAddr,
  input  logic [31:0]    hostWdata,
  output logic [31:0]    hostRdata,
  output logic           hostIrq,
  input  logic           remWe,
  input  logic [IW-1:0]  remAddr,
  input  logic [31:0]    remWdata,
  output logic [31:0]    remRdata,
  input  logic [NCH-1:0] txAck,
  input  logic [NCH-1:0] rxPost,
  output logic [NCH-1:0] txPending
);
  mbxStrb_t    strb;
  logic [31:0] hostDataRd;

  mbx_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .clk, .rstN, .hostWe, .hostCtl, .hostAddr, .hostWdata,
    .hostDataRd, .hostRdata, .strb, .txAck, .rxPost, .txPending, .hostIrq
  );

  mbx_datapath #(.WORDS(WORDS), .IW(IW)) u_data (
    .clk, .rstN, .strb, .remWe, .remAddr, .remWdata, .remRdata, .hostDataRd
  );
endmodule

// File: tb/tb_mbx_doorbell_top.sv
`timescale 1ns/1ps
module tb_mbx_doorbell_top;
  logic clk = 0, rstN = 0;
  logic hostWe = 0, hostCtl = 0, remWe = 0;
  logic [8:0] hostAddr = 0;
  logic [31:0] hostWdata = 0, remWdata = 0;
  logic [6:0] remAddr = 0;
  logic [11:0] txAck = 0, rxPost = 0;
  logic [31:0] hostRdata, remRdata;
  logic hostIrq;
  logic [11:0] txPending;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] mMem [92];
  logic [11:0] mTx, mRx;

  always #4 clk = ~clk;

  mbx_doorbell_top dut (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 0;
      mTx = 0; mRx = 0;
    end else begin
      if (hostWe && !hostCtl && hostAddr < 9'h170) mMem[hostAddr >> 2] = hostWdata;
      if (remWe && remAddr < 92) mMem[remAddr] = remWdata;
      mTx = (mTx & ~txAck) | ((hostWe && hostCtl && hostAddr[8:2] == 1) ? hostWdata[11:0] : 12'h0);
      mRx = (mRx & ~((hostWe && hostCtl && hostAddr[8:2] == 29) ? hostWdata[11:0] : 12'h0)) | rxPost;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3 R7: pins against the model on every clock
  always @(negedge clk) if (rstN && !done) begin
    chk("R3 txPending", {20'h0, txPending}, {20'h0, mTx});
    chk("R7 hostIrq", {31'h0, hostIrq}, {31'h0, (mRx != 0)});
  end

  function automatic logic [31:0] expRead(logic ctl, logic [8:0] a);
    if (ctl) begin
      if (a[8:2] == 0)  return {20'h0, mTx};
      if (a[8:2] == 30) return {20'h0, mRx};
      return 0;
    end
    return (a < 9'h170) ? mMem[a >> 2] : 0;
  endfunction

  task automatic idle();
    hostWe = 0; remWe = 0; txAck = 0; rxPost = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic hWr(logic ctl, logic [8:0] a, logic [31:0] d);
    hostWe = 1; hostCtl = ctl; hostAddr = a; hostWdata = d; cyc();
  endtask

  task automatic hRd(string tag, logic ctl, logic [8:0] a);
    hostWe = 0; hostCtl = ctl; hostAddr = a; #1;
    chk(tag, hostRdata, expRead(ctl, a));
    cyc();
  endtask

  task automatic rRd(string tag, logic [6:0] a);
    remAddr = a; #1;
    chk(tag, remRdata, (a < 92) ? mMem[a] : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 txPending", {20'h0, txPending}, 0);
    chk("R1 hostIrq", {31'h0, hostIrq}, 0);
    hRd("R1 txstat", 1, 9'h000);
    hRd("R1 rxstat", 1, 9'h078);
    // R2 host fills channel 1 outgoing slot, remote reads it
    for (int i = 0; i < 8; i++) hWr(0, 9'h010 + 9'(4*i), 32'hA500_0000 + i);
    for (int i = 0; i < 8; i++) rRd("R2 remote read", 7'(4 + i));
    hRd("R2 host read", 0, 9'h014);
    // R3 doorbells on ch1 and ch7
    hWr(1, 9'h004, 32'hFFFF_0082);
    hRd("R4 txstat", 1, 9'h000);
    // R4 ack ch1
    txAck = 12'h002; cyc();
    hRd("R4 after ack", 1, 9'h000);
    // R4 ring and ack ch7 together: set wins
    txAck = 12'h080; hostWe = 1; hostCtl = 1; hostAddr = 9'h004; hostWdata = 32'h80; cyc();
    hRd("R4 ring vs ack", 1, 9'h000);
    txAck = 12'h080; cyc();
    hRd("R4 cleared", 1, 9'h000);
    // R2 remote fills ch0 incoming slot; R5 post ch0 and ch11
    for (int i = 0; i < 4; i++) begin
      remWe = 1; remAddr = 7'(56 + i); remWdata = 32'h5A00_0010 + i; cyc();
    end
    for (int i = 0; i < 4; i++) hRd("R2 host sees remote", 0, 9'h0E0 + 9'(4*i));
    rxPost = 12'h801; cyc();
    hRd("R5 rxstat", 1, 9'h078);
    // R6 zero bits do nothing
    hWr(1, 9'h074, 32'hFFFF_F000);
    hRd("R6 zero clear", 1, 9'h078);
    hWr(1, 9'h074, 32'h1);
    hRd("R6 clear ch0", 1, 9'h078);
    // R6 clear and post on ch11 together: post wins
    rxPost = 12'h800; hostWe = 1; hostCtl = 1; hostAddr = 9'h074; hostWdata = 32'h800; cyc();
    hRd("R6 post wins", 1, 9'h078);
    hWr(1, 9'h074, 32'h800);
    hRd("R7 all clear", 1, 9'h078);
    // R8 status writes ignored; other offsets read zero
    hWr(1, 9'h004, 32'h10);
    hWr(1, 9'h000, 32'hFFFF_FFFF);
    hWr(1, 9'h078, 32'hFFFF_FFFF);
    hRd("R8 txstat ro", 1, 9'h000);
    hRd("R8 rxstat ro", 1, 9'h078);
    hRd("R8 ring reads 0", 1, 9'h004);
    hRd("R8 clr reads 0", 1, 9'h074);
    hRd("R8 unused reads 0", 1, 9'h040);
    // R9 out-of-range data
    hWr(0, 9'h170, 32'hDEAD_BEEF);
    hRd("R9 host oor", 0, 9'h170);
    hRd("R9 host oor top", 0, 9'h1FC);
    remWe = 1; remAddr = 7'd100; remWdata = 32'h1234; cyc();
    rRd("R9 remote oor", 7'd100);
    hRd("R9 last word", 0, 9'h16C);
    // R10 collision on word 0x16C
    hostWe = 1; hostCtl = 0; hostAddr = 9'h16C; hostWdata = 32'h1111_1111;
    remWe = 1; remAddr = 7'd91; remWdata = 32'h2222_2222; cyc();
    hRd("R10 remote wins", 0, 9'h16C);
    chk("R10 value", mMem[91], 32'h2222_2222);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule